// File: doc/BRIEF.md
# Open-Bus Partial Input Port

This block models a memory-mapped input port on a shared 8-bit data bus that carries a bus-keeper latch. Each clock cycle stands for one bus cycle. An external cycle stream supplies an address, a read strobe, a write strobe, and an indication that a memory agent (a ROM or RAM model) is driving a given byte. The keeper holds the last byte that any agent placed on the bus. When nothing drives the bus, that held byte is what a reader sees.

The port drives only the top two bits of its registers. Bit 7 carries a registered input pin and bit 6 is driven low. The six low bits are never driven by the port, so a port read returns whatever the bus held last. This means the value read depends on the bus cycles just before the read. After a zero-page operand fetch, the low bits echo the address byte. After an absolute-mode fetch, they echo the address high byte. After the discarded first read of an indexed zero-page access, they echo that read's result. The output `bus_byte` is the byte the CPU samples in the current cycle.

Each cycle is sorted into one of four named cycle kinds: `CYC_WRITE` (the CPU drives write data), `CYC_PORT` (a read hits a port channel), `CYC_MEM` (a read answered by a memory agent) and `CYC_FLOAT` (nobody drives the bus). The keeper has one state register. Its transitions are: load the write byte on `CYC_WRITE`, load the memory byte on `CYC_MEM`, load the port composite on `CYC_PORT`, and hold on `CYC_FLOAT`.

Top module: `open_bus_port`

## Requirements
- R1: While and after reset, the keeper value is 0x00 and every registered pin is 0, so a cycle with no driver returns 0x00.
- R2: Input pins are registered once per cycle. Bit 7 of a port read equals the pin level present one clock edge before that read cycle.
- R3: On a port read, bit 6 of `bus_byte` is 0.
- R4: On a port read, bits 5 to 0 of `bus_byte` equal bits 5 to 0 of the keeper value.
- R5: Channel i (0 to NUM_CH-1) is decoded only at the full address PORT_BASE+i. With the defaults, channel 2 is at 0x000A and channel 3 is at 0x000B. Addresses such as 0x000C and 0x010A are not port addresses.
- R6: After every driven cycle (write, memory read or port read), the keeper holds exactly the `bus_byte` of that cycle.
- R7: On a cycle with no driver (no write, no port hit, and no memory drive on a read), `bus_byte` equals the keeper value and the keeper holds.
- R8: When `wr` is high, `bus_byte` equals `wdata` whatever `rd`, the address and `mem_drive` are. This includes a write to a port address.
- R9: On a port read, `mem_drive` and `mem_data` have no effect. Their value shows neither in `bus_byte` nor in the keeper.
- R10: `mem_drive` counts only on a read cycle. With `rd` and `wr` both low, the cycle floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (16) | Address of the current bus cycle |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (has priority over rd) |
| mem_drive | input | 1 | A memory agent drives mem_data on this read |
| mem_data | input | 8 | Byte driven by the memory agent |
| wdata | input | 8 | Byte driven by the CPU on a write |
| in_pins | input | NUM_CH (4) | Raw input pin levels, one per channel |
| bus_byte | output | 8 | Byte present on the data bus this cycle |

## Verification
The riskiest collision is a port read landing in the same cycle as the keeper update. That read both takes its low bits from the keeper and rewrites the keeper with its own top bits. The indexed zero-page sequence provokes this: a discarded read of channel 2 is followed at once by a read of channel 3. That second read must return channel 3's pin above channel 2's earlier low bits. The second collision is a pin edge arriving in the very cycle of a port read. The bench changes pins during port reads and expects the older registered level on bit 7. A bench model of keeper and pin registers judges each cycle, and random cycles mix all four cycle kinds back to back.

// File: rtl/obp_pkg.sv
package obp_pkg;

    typedef enum logic [1:0] {
        CYC_FLOAT = 2'd0,
        CYC_MEM   = 2'd1,
        CYC_PORT  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_kind_e;

    localparam int unsigned BUS_W     = 8;
    localparam int unsigned FLOAT_LSB = 0;
    localparam int unsigned FLOAT_MSB = 5;

endpackage

// File: rtl/obp_decode.sv
module obp_decode
    import obp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PORT_BASE = 8,
    parameter int unsigned NUM_CH    = 4,
    localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              mem_drive,
    output cyc_kind_e         kind,
    output logic [CH_W-1:0]   ch_idx
);

    logic [NUM_CH-1:0] hit_vec;

    generate
        for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_match
            assign hit_vec[gi] = (addr == ADDR_W'(PORT_BASE + gi));
        end
    endgenerate

    always_comb begin
        ch_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_vec[i]) ch_idx = CH_W'(i);
        end
    end

    always_comb begin
        unique casez ({wr, rd, |hit_vec, mem_drive})
            4'b1???: kind = CYC_WRITE;
            4'b011?: kind = CYC_PORT;
            4'b0101: kind = CYC_MEM;
            default: kind = CYC_FLOAT;
        endcase
    end

    // R5: at most one channel answers a given address
    assert_one_channel_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R10: no memory cycle without a read strobe
    assert_mem_needs_read_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd && !wr) |-> (kind == CYC_FLOAT));

endmodule

// File: rtl/obp_pin_sync.sv
module obp_pin_sync #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pins_raw,
    output logic [NUM_CH-1:0] pins_q
);

    always_ff @(posedge clk) begin
        if (rst) pins_q <= '0;
        else     pins_q <= pins_raw;
    end

    // R2: one register stage between pin and port bit
    assert_pin_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pins_q == $past(pins_raw)));

endmodule

// File: rtl/obp_keeper.sv
module obp_keeper
    import obp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cyc_kind_e        kind,
    input  logic [BUS_W-1:0] mem_data,
    input  logic [BUS_W-1:0] wdata,
    input  logic             port_bit,
    output logic [BUS_W-1:0] bus_byte,
    output logic [BUS_W-1:0] keep_q
);

    logic bus_driven;

    always_comb begin
        bus_driven = 1'b1;
        unique case (kind)
            CYC_WRITE: bus_byte = wdata;
            CYC_MEM:   bus_byte = mem_data;
            CYC_PORT:  bus_byte = {port_bit, 1'b0, keep_q[FLOAT_MSB:FLOAT_LSB]};
            CYC_FLOAT: begin
                bus_byte   = keep_q;
                bus_driven = 1'b0;
            end
            default: begin
                bus_byte   = keep_q;
                bus_driven = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)             keep_q <= '0;
        else if (bus_driven) keep_q <= bus_byte;
    end

    // R6: a driven cycle leaves its byte in the keeper
    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (kind != CYC_FLOAT) |=> (keep_q == $past(bus_byte)));

    // R7: an undriven cycle leaves the keeper alone
    assert_float_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_FLOAT) |=> (keep_q == $past(keep_q)));

endmodule

// File: rtl/open_bus_port.sv
module open_bus_port
    import obp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PORT_BASE = 8,
    parameter int unsigned NUM_CH    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              mem_drive,
    input  logic [7:0]        mem_data,
    input  logic [7:0]        wdata,
    input  logic [NUM_CH-1:0] in_pins,
    output logic [7:0]        bus_byte
);

    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    cyc_kind_e         kind;
    logic [CH_W-1:0]   ch_idx;
    logic [NUM_CH-1:0] pins_q;
    logic [7:0]        keep_q;
    logic              port_bit;

    obp_decode #(
        .ADDR_W   (ADDR_W),
        .PORT_BASE(PORT_BASE),
        .NUM_CH   (NUM_CH)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .rd       (rd),
        .wr       (wr),
        .mem_drive(mem_drive),
        .kind     (kind),
        .ch_idx   (ch_idx)
    );

    obp_pin_sync #(.NUM_CH(NUM_CH)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .pins_raw(in_pins),
        .pins_q  (pins_q)
    );

    assign port_bit = pins_q[ch_idx];

    obp_keeper u_keeper (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .mem_data(mem_data),
        .wdata   (wdata),
        .port_bit(port_bit),
        .bus_byte(bus_byte),
        .keep_q  (keep_q)
    );

    // R3: bit 6 of a port read is low
    assert_bit6_low_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && kind == CYC_PORT) |-> !bus_byte[6]);

    // R4: low bits of a port read come from the keeper
    assert_low_bits_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (kind == CYC_PORT) |-> (bus_byte[5:0] == keep_q[5:0]));

    // R8: write data owns the bus
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        wr |-> (bus_byte == wdata));

endmodule

// File: tb/open_bus_port_tb.sv
module open_bus_port_tb_top;

    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned PORT_BASE = 8;
    localparam int unsigned NUM_CH    = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd = 1'b0, wr = 1'b0, mem_drive = 1'b0;
    logic [7:0]        mem_data = '0, wdata = '0;
    logic [NUM_CH-1:0] in_pins = '0;
    logic [7:0]        bus_byte;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;

    logic [7:0]        m_keep = 8'h00;
    logic [NUM_CH-1:0] m_pins = '0;

    always #2.5 clk = ~clk;

    open_bus_port #(
        .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE), .NUM_CH(NUM_CH)
    ) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr),
        .mem_drive(mem_drive), .mem_data(mem_data), .wdata(wdata),
        .in_pins(in_pins), .bus_byte(bus_byte)
    );

    function automatic bit is_port(input logic [ADDR_W-1:0] a);
        return (a >= ADDR_W'(PORT_BASE)) && (a < ADDR_W'(PORT_BASE + NUM_CH));
    endfunction

    // expected bus byte, and whether the bus is driven this cycle
    function automatic logic [8:0] expect_bus(
        input logic [ADDR_W-1:0] a, input logic r, input logic w,
        input logic md, input logic [7:0] mdat, input logic [7:0] wd);
        if (w)                return {1'b1, wd};
        if (r && is_port(a))  return {1'b1, m_pins[a - ADDR_W'(PORT_BASE)], 1'b0, m_keep[5:0]};
        if (r && md)          return {1'b1, mdat};
        return {1'b0, m_keep};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bus_byte=%02h expected=%02h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [ADDR_W-1:0] a, input logic r, input logic w,
                       input logic md, input logic [7:0] mdat, input logic [7:0] wd,
                       input logic [NUM_CH-1:0] pins, input string req);
        logic [8:0] e;
        @(negedge clk);
        addr = a; rd = r; wr = w; mem_drive = md; mem_data = mdat; wdata = wd; in_pins = pins;
        #1;
        e = expect_bus(a, r, w, md, mdat, wd);
        check(req, bus_byte, e[7:0]);
        @(posedge clk);
        if (e[8]) m_keep = e[7:0];
        m_pins = pins;
    endtask

    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [NUM_CH-1:0] p;
        // R1: reset state
        in_pins = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 check("R1 during reset", bus_byte, 8'h00);
        rst = 1'b0;
        m_keep = 8'h00; m_pins = '0;
        cyc(16'h0080, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'b1111, "R1 float after reset");
        cyc(16'h000A, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b1111, "R1 R2 pins now high");

        // zero-page read of channel 2: operand fetch puts 0x0A on the bus (R4)
        cyc(16'hF000, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h00, 4'b0100, "R6 opcode fetch");
        cyc(16'hF001, 1'b1, 1'b0, 1'b1, 8'h0A, 8'h00, 4'b0100, "R6 operand fetch");
        cyc(16'h000A, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b0000, "R4 R5 zp read ch2 -> 8A");

        // absolute read of channel 3: high byte 0x00 last (R4)
        cyc(16'hF002, 1'b1, 1'b0, 1'b1, 8'h0B, 8'h00, 4'b1000, "R6 abs low byte");
        cyc(16'hF003, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 4'b1000, "R6 abs high byte");
        cyc(16'h000B, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b0000, "R4 R5 abs read ch3 -> 80");

        // indexed zp, base 0x0A, X=1: dummy port read then ch3 (R6 + R2 pin edge in read cycle)
        cyc(16'hF004, 1'b1, 1'b0, 1'b1, 8'h0A, 8'h00, 4'b0100, "R6 operand 0A");
        cyc(16'h000A, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b0000, "R6 dummy ch2 read");
        cyc(16'h000B, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b1000, "R2 R4 ch3 after dummy -> 0A");

        // indexed zp, base 0x80, X=0x8A: dummy RAM read, wraps to 0x0A
        cyc(16'hF006, 1'b1, 1'b0, 1'b1, 8'h80, 8'h00, 4'b0100, "R6 operand 80");
        cyc(16'h0080, 1'b1, 1'b0, 1'b1, 8'h75, 8'h00, 4'b0100, "R6 dummy RAM read");
        cyc(16'h000A, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b0100, "R3 R4 ch2 after RAM -> B5");

        // R9: memory drive on a port address is ignored, keeper shows it afterwards
        cyc(16'hF008, 1'b1, 1'b0, 1'b1, 8'h15, 8'h00, 4'b0000, "R6 load 15");
        cyc(16'h0009, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 4'b0000, "R9 port read with mem drive");
        cyc(16'h0300, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'b0000, "R9 keeper after port read");

        // R5: non-port addresses float
        cyc(16'h000C, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b1111, "R5 0x000C not a port");
        cyc(16'h010A, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b1111, "R5 0x010A not a port");

        // R8: write to a port address with rd and mem drive high
        cyc(16'h000A, 1'b1, 1'b1, 1'b1, 8'h11, 8'hC3, 4'b1111, "R8 write over read");
        cyc(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 4'b1111, "R7 keeper holds C3");
        // R10: mem_drive without strobe floats
        cyc(16'h0090, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h00, 4'b1111, "R10 mem drive no read");
        cyc(16'h0008, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'b1111, "R4 R10 port after float");

        // constrained random mix
        void'($urandom(32'd20240607));
        for (int i = 0; i < 4000; i++) begin
            logic [ADDR_W-1:0] a;
            logic r, w, md;
            int unsigned sel = $urandom_range(0, 9);
            a = (sel < 5) ? ADDR_W'($urandom_range(PORT_BASE - 2, PORT_BASE + NUM_CH + 1))
                          : ADDR_W'($urandom);
            w  = ($urandom_range(0, 7) == 0);
            r  = ($urandom_range(0, 4) != 0);
            md = $urandom_range(0, 1);
            p  = NUM_CH'($urandom);
            cyc(a, r, w, md, 8'($urandom), 8'($urandom), p,
                w ? "R8 random" : (r && is_port(a)) ? "R2 R3 R4 random" :
                (r && md) ? "R6 random" : "R7 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule